// File: doc/BRIEF.md
# Indirect Effective Address Sequencer

This block works out the 24-bit effective address for the indirect addressing forms of a 16-bit accumulator CPU that uses bank registers. The decode logic pulses `start` with a mode code, and it presents the current program counter, the direct-page base, the X index and the data bank value. The sequencer then runs the whole job on its own over a byte-wide read port. It reads the operand bytes that follow the opcode and advances the program counter by one for each byte. Next it builds a 16-bit pointer in bank zero and reads two or three bytes through that pointer. Last, it assembles the result. A one-cycle `done` pulse then presents the effective address together with the advanced program counter.

The sequencer supports five modes. Two of them take a two-byte absolute operand, one plain and one with X added. Two take a one-byte direct-page operand added to the base: one puts the data bank in the top byte, and the long variant reads the top byte from memory. The fifth mode, program-counter-relative long, does no pointer reads. It adds a signed 16-bit operand to the advanced counter.

The FSM states are IDLE, OP_LO, OP_HI, CALC, PTR0, PTR1, PTR2, FIN and DONE. IDLE moves to OP_LO on an accepted start. OP_LO moves to OP_HI for two-byte operands and to CALC for one-byte operands. OP_HI moves to CALC. CALC moves to DONE in relative mode and to PTR0 otherwise. PTR0 moves to PTR1. PTR1 moves to PTR2 in long mode and to FIN otherwise. PTR2 moves to FIN, FIN moves to DONE, and DONE returns to IDLE.

Top module: `ind_ea_seq`

## Requirements
- R1: A synchronous reset, applied at any time, returns the sequencer to IDLE with `done` and `mem_req` low and with `ea` and `pc_out` reading zero.
- R2: Operand bytes are read low byte first, starting at the program counter latched at start. Each read byte advances the counter by one, with 24-bit wrap. Modes 0, 1 and 4 read two operand bytes and modes 2 and 3 read one.
- R3: Mode 0 (absolute indirect) reads bytes at P and P+1, where P is the 16-bit operand. The result is `{8'h00, byte[P+1], byte[P]}`.
- R4: Mode 1 (absolute indexed indirect) uses P = operand + X, taken modulo 2^16, and builds the result as in mode 0.
- R5: Mode 2 (direct indirect) uses P = D + operand, taken modulo 2^16. The result is `{DBR, byte[P+1], byte[P]}`.
- R6: Mode 3 (direct indirect long) reads bytes at P, P+1 and P+2, with P formed as in mode 2. The third byte forms bits 23:16 and DBR is ignored.
- R7: Every pointer read goes to bank zero, and the byte steps P+1 and P+2 wrap within 16 bits.
- R8: Mode 4 (relative long) adds the sign-extended 16-bit operand to the advanced program counter, with 24-bit wrap, and reads no pointer bytes.
- R9: The read port issues at most one byte request per cycle and takes the data in the cycle after the request. An operation issues exactly its operand reads followed by its pointer reads, in address order.
- R10: A `start` that arrives outside IDLE has no effect, and so does a `start` with a reserved mode code (5, 6 or 7). Neither causes any extra request or `done` pulse.
- R11: `done` is high for exactly one cycle per operation, and `ea` and `pc_out` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted only in IDLE) |
| mode | input | 3 | Mode code 0..4, 5..7 reserved |
| pc_in | input | 24 | Program counter pointing at the first operand byte |
| d_reg | input | 16 | Direct-page base |
| x_reg | input | 16 | X index |
| dbr | input | 8 | Data bank |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 24 | Effective address |
| pc_out | output | 24 | Advanced program counter |

## Verification
The bench places pointers where the 16-bit sum or the byte step wraps: an X sum that rolls over to 0x0000, and a direct-page pointer at 0xFFFF. A design that carried into the bank byte would fetch from bank one and return the wrong bytes. A relative offset with the sign bit set, and a program counter that wraps past 0xFFFFFF, expose missing sign extension or a wrong counter width. Start pulses sent mid-operation, in the DONE cycle and with reserved codes would produce extra requests or a second `done` pulse in a design that accepts them. A long-mode run with a DBR value that differs from the third byte shows whether the wrong bank source was used.

// File: rtl/ind_ea_pkg.sv
package ind_ea_pkg;

    localparam int EA_ADDR_W = 24;
    localparam int EA_PTR_W  = 16;
    localparam int EA_BYTE_W = 8;

    typedef enum logic [2:0] {
        M_ABS_IND     = 3'd0,
        M_ABS_X_IND   = 3'd1,
        M_DP_IND      = 3'd2,
        M_DP_IND_LONG = 3'd3,
        M_PC_REL_LONG = 3'd4
    } mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OP_LO,
        S_OP_HI,
        S_CALC,
        S_PTR0,
        S_PTR1,
        S_PTR2,
        S_FIN,
        S_DONE
    } state_e;

    function automatic logic mode_known(input logic [2:0] m);
        return m <= 3'd4;
    endfunction

    function automatic logic two_byte_operand(input mode_e m);
        return (m == M_ABS_IND) || (m == M_ABS_X_IND) || (m == M_PC_REL_LONG);
    endfunction

endpackage

// File: rtl/ind_ea_ptr.sv
module ind_ea_ptr
    import ind_ea_pkg::*;
#(
    parameter int PTR_W = EA_PTR_W
) (
    input  mode_e             mode,
    input  logic [PTR_W-1:0]  operand,
    input  logic [PTR_W-1:0]  idx_x,
    input  logic [PTR_W-1:0]  dp_base,
    output logic [PTR_W-1:0]  ptr
);

    // Sums are PTR_W wide, so they wrap inside bank zero.
    always_comb begin
        case (mode)
            M_ABS_X_IND:   ptr = operand + idx_x;
            M_DP_IND,
            M_DP_IND_LONG: ptr = dp_base + operand;
            default:       ptr = operand;
        endcase
    end

endmodule

// File: rtl/ind_ea_compose.sv
module ind_ea_compose
    import ind_ea_pkg::*;
#(
    parameter int ADDR_W = EA_ADDR_W,
    parameter int PTR_W  = EA_PTR_W,
    parameter int BYTE_W = EA_BYTE_W
) (
    input  mode_e              mode,
    input  logic [BYTE_W-1:0]  b0,
    input  logic [BYTE_W-1:0]  b1,
    input  logic [BYTE_W-1:0]  b2,
    input  logic [BYTE_W-1:0]  bank,
    input  logic [ADDR_W-1:0]  pc_cur,
    input  logic [PTR_W-1:0]   operand,
    output logic [ADDR_W-1:0]  ea
);

    localparam int BANK_W = ADDR_W - PTR_W;

    logic [ADDR_W-1:0] rel_offset;
    assign rel_offset = {{BANK_W{operand[PTR_W-1]}}, operand};

    always_comb begin
        case (mode)
            M_DP_IND:      ea = {bank, b1, b0};
            M_DP_IND_LONG: ea = {b2, b1, b0};
            M_PC_REL_LONG: ea = pc_cur + rel_offset;
            default:       ea = {{BANK_W{1'b0}}, b1, b0};
        endcase
    end

endmodule

// File: rtl/ind_ea_seq.sv
module ind_ea_seq
    import ind_ea_pkg::*;
#(
    parameter int ADDR_W = EA_ADDR_W,
    parameter int PTR_W  = EA_PTR_W,
    parameter int BYTE_W = EA_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [PTR_W-1:0]  d_reg,
    input  logic [PTR_W-1:0]  x_reg,
    input  logic [BYTE_W-1:0] dbr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] pc_out
);

    localparam int BANK_W = ADDR_W - PTR_W;
    localparam int HI_W   = PTR_W - BYTE_W;
    localparam logic [PTR_W-1:0]  STEP1 = PTR_W'(1);
    localparam logic [PTR_W-1:0]  STEP2 = PTR_W'(2);
    localparam logic [ADDR_W-1:0] PC_INC = ADDR_W'(1);

    state_e            state_q, state_d;
    mode_e             mode_q;
    logic [ADDR_W-1:0] pc_q;
    logic [PTR_W-1:0]  d_q, x_q, ptr_q, op_q;
    logic [BYTE_W-1:0] op_lo_q, b0_q, b1_q, b2_q, dbr_q;

    logic              accept, two_byte, long_ptr, rel_mode;
    logic [PTR_W-1:0]  operand_now, ptr_next;

    assign accept   = (state_q == S_IDLE) && start && mode_known(mode);
    assign two_byte = two_byte_operand(mode_q);
    assign long_ptr = (mode_q == M_DP_IND_LONG);
    assign rel_mode = (mode_q == M_PC_REL_LONG);

    // In CALC the last operand byte is still on the read bus.
    assign operand_now = two_byte ? {mem_rdata, op_lo_q}
                                  : {{HI_W{1'b0}}, mem_rdata};

    ind_ea_ptr #(.PTR_W(PTR_W)) u_ptr (
        .mode    (mode_q),
        .operand (operand_now),
        .idx_x   (x_q),
        .dp_base (d_q),
        .ptr     (ptr_next)
    );

    ind_ea_compose #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_compose (
        .mode    (mode_q),
        .b0      (b0_q),
        .b1      (b1_q),
        .b2      (b2_q),
        .bank    (dbr_q),
        .pc_cur  (pc_q),
        .operand (op_q),
        .ea      (ea)
    );

    assign pc_out = pc_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = accept   ? S_OP_LO : S_IDLE;
            S_OP_LO: state_d = two_byte ? S_OP_HI : S_CALC;
            S_OP_HI: state_d = S_CALC;
            S_CALC:  state_d = rel_mode ? S_DONE  : S_PTR0;
            S_PTR0:  state_d = S_PTR1;
            S_PTR1:  state_d = long_ptr ? S_PTR2  : S_FIN;
            S_PTR2:  state_d = S_FIN;
            S_FIN:   state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= M_ABS_IND;
            pc_q    <= '0;
            d_q     <= '0;
            x_q     <= '0;
            dbr_q   <= '0;
            ptr_q   <= '0;
            op_q    <= '0;
            op_lo_q <= '0;
            b0_q    <= '0;
            b1_q    <= '0;
            b2_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (accept) begin
                    mode_q <= mode_e'(mode);
                    pc_q   <= pc_in;
                    d_q    <= d_reg;
                    x_q    <= x_reg;
                    dbr_q  <= dbr;
                end
                S_OP_LO: pc_q <= pc_q + PC_INC;
                S_OP_HI: begin
                    pc_q    <= pc_q + PC_INC;
                    op_lo_q <= mem_rdata;
                end
                S_CALC: begin
                    op_q  <= operand_now;
                    ptr_q <= ptr_next;
                end
                S_PTR1: b0_q <= mem_rdata;
                S_PTR2: b1_q <= mem_rdata;
                S_FIN: begin
                    if (long_ptr) b2_q <= mem_rdata;
                    else          b1_q <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        done     = 1'b0;
        unique case (state_q)
            S_OP_LO, S_OP_HI: begin
                mem_req  = 1'b1;
                mem_addr = pc_q;
            end
            S_PTR0: begin
                mem_req  = 1'b1;
                mem_addr = {{BANK_W{1'b0}}, ptr_q};
            end
            S_PTR1: begin
                mem_req  = 1'b1;
                mem_addr = {{BANK_W{1'b0}}, ptr_q + STEP1};
            end
            S_PTR2: begin
                mem_req  = 1'b1;
                mem_addr = {{BANK_W{1'b0}}, ptr_q + STEP2};
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    // Assertions
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_OP_LO) |=> (pc_q == $past(pc_q) + PC_INC));

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PTR0) |=>
            (mem_addr == {{BANK_W{1'b0}}, $past(mem_addr[PTR_W-1:0]) + STEP1}));

    p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE && start) |=> ($stable(mode_q) && $stable(d_q)));

    p_reserved_mode_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && start && mode > 3'd4) |=> (!mem_req && state_q == S_IDLE));

    p_dp_bank_r5: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == M_DP_IND) |-> (ea[ADDR_W-1:PTR_W] == dbr_q));

    p_req_states_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (state_q inside {S_OP_LO, S_OP_HI, S_PTR0, S_PTR1, S_PTR2}));

endmodule

// File: tb/test_ind_ea_seq.sv
module test_ind_ea_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [23:0] pc_in = '0;
    logic [15:0] d_reg = '0;
    logic [15:0] x_reg = '0;
    logic [7:0]  dbr = '0;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [23:0] ea;
    logic [23:0] pc_out;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [int unsigned];
    logic [23:0] log_a [0:15];
    int          log_n = 0;
    int          done_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_ea_seq i_ind_ea_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .pc_in(pc_in),
        .d_reg(d_reg), .x_reg(x_reg), .dbr(dbr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
        .ea(ea), .pc_out(pc_out)
    );

    function automatic logic [7:0] rd(input logic [23:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ 8'hA5;
    endfunction

    // Byte memory with one cycle of read latency
    always @(posedge clk) if (mem_req) mem_rdata <= rd(mem_addr);

    // Request log and done counter, sampled away from the active edge
    always @(negedge clk) begin
        if (mem_req) begin
            if (log_n < 16) log_a[log_n] = mem_addr;
            log_n = log_n + 1;
        end
        if (done) done_cnt = done_cnt + 1;
    end

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input string rq, input logic [2:0] m, input logic [23:0] pc,
                         input logic [15:0] dv, input logic [15:0] xv, input logic [7:0] bank,
                         input logic [23:0] exp_ea, input logic [23:0] exp_pc,
                         input logic [23:0] exp_ptr, input int nbytes, input int nop,
                         input bit bump);
        bit seen = 0;
        @(negedge clk);
        log_n = 0; done_cnt = 0;
        start = 1; mode = m; pc_in = pc; d_reg = dv; x_reg = xv; dbr = bank;
        @(negedge clk);
        start = 0; pc_in = '0; d_reg = '0; x_reg = '0; dbr = '0;
        for (int i = 0; i < 40; i++) begin
            if (done) begin seen = 1; break; end
            start = bump && (i == 1);
            if (bump) begin mode = 3'd2; pc_in = 24'h123456; end
            @(negedge clk);
        end
        start = 0;
        chk(rq, "done seen", 32'(seen), 32'd1);
        chk(rq, "ea", 32'(ea), 32'(exp_ea));
        chk(rq, "pc_out", 32'(pc_out), 32'(exp_pc));
        chk(rq, "request count", 32'(log_n), 32'(nbytes));
        chk("R2", {rq, " first operand address"}, 32'(log_a[0]), 32'(pc));
        if (nop < nbytes)
            chk("R9", {rq, " first pointer address"}, 32'(log_a[nop]), 32'(exp_ptr));
        if (bump) start = 1;
        @(negedge clk);
        start = 0;
        chk("R11", {rq, " done low after pulse"}, 32'(done), 32'd0);
        repeat (8) @(negedge clk);
        chk("R11", {rq, " single done pulse"}, 32'(done_cnt), 32'd1);
        chk("R10", {rq, " no extra requests"}, 32'(log_n), 32'(nbytes));
    endtask

    task automatic t_reset;
        chk("R1", "done in reset", 32'(done), 32'd0);
        chk("R1", "mem_req in reset", 32'(mem_req), 32'd0);
        chk("R1", "ea in reset", 32'(ea), 32'd0);
        chk("R1", "pc_out in reset", 32'(pc_out), 32'd0);
    endtask

    task automatic t_abs_ind;
        mem.delete();
        mem[32'h808000] = 8'hAB; mem[32'h808001] = 8'h01;
        mem[32'h0001AB] = 8'hEF; mem[32'h0001AC] = 8'h01;
        do_op("R3", 3'd0, 24'h808000, 16'h1234, 16'h0002, 8'h77,
              24'h0001EF, 24'h808002, 24'h0001AB, 4, 2, 0);
    endtask

    task automatic t_abs_x_ind;
        mem.delete();
        mem[32'h808000] = 8'hAB; mem[32'h808001] = 8'h01;
        mem[32'h0001AD] = 8'h34; mem[32'h0001AE] = 8'h12;
        do_op("R4", 3'd1, 24'h808000, 16'h0000, 16'h0002, 8'h55,
              24'h001234, 24'h808002, 24'h0001AD, 4, 2, 0);
    endtask

    task automatic t_abs_x_wrap;
        mem.delete();
        mem[32'h200000] = 8'hFF; mem[32'h200001] = 8'hFF;
        mem[32'h000000] = 8'h34; mem[32'h000001] = 8'h12;
        do_op("R7", 3'd1, 24'h200000, 16'h0000, 16'h0001, 8'h00,
              24'h001234, 24'h200002, 24'h000000, 4, 2, 0);
    endtask

    task automatic t_dp_ind;
        mem.delete();
        mem[32'h808000] = 8'h01;
        mem[32'h001011] = 8'hEF; mem[32'h001012] = 8'h01;
        do_op("R5", 3'd2, 24'h808000, 16'h1010, 16'h0000, 8'h88,
              24'h8801EF, 24'h808001, 24'h001011, 3, 1, 0);
    endtask

    task automatic t_dp_wrap;
        mem.delete();
        mem[32'h400000] = 8'h00;
        mem[32'h00FFFF] = 8'h5C; mem[32'h000000] = 8'h77;
        do_op("R7", 3'd2, 24'h400000, 16'hFFFF, 16'h0000, 8'h12,
              24'h12775C, 24'h400001, 24'h00FFFF, 3, 1, 0);
    endtask

    task automatic t_dp_long;
        mem.delete();
        mem[32'h808000] = 8'h06;
        mem[32'h001016] = 8'hEF; mem[32'h001017] = 8'h01; mem[32'h001018] = 8'h88;
        do_op("R6", 3'd3, 24'h808000, 16'h1010, 16'h0000, 8'h33,
              24'h8801EF, 24'h808001, 24'h001016, 4, 1, 0);
    endtask

    task automatic t_pc_rel;
        mem.delete();
        mem[32'h808010] = 8'h00; mem[32'h808011] = 8'h80;
        do_op("R8", 3'd4, 24'h808010, 16'h0000, 16'h0000, 8'h00,
              24'h800012, 24'h808012, 24'h0, 2, 2, 0);
        mem[32'h808010] = 8'h00; mem[32'h808011] = 8'h01;
        do_op("R8", 3'd4, 24'h808010, 16'h0000, 16'h0000, 8'h00,
              24'h808112, 24'h808012, 24'h0, 2, 2, 0);
        mem[32'hFFFFFE] = 8'h05; mem[32'hFFFFFF] = 8'h00;
        do_op("R2", 3'd4, 24'hFFFFFE, 16'h0000, 16'h0000, 8'h00,
              24'h000005, 24'h000000, 24'h0, 2, 2, 0);
    endtask

    task automatic t_busy_start;
        mem.delete();
        mem[32'h808000] = 8'hAB; mem[32'h808001] = 8'h01;
        mem[32'h0001AB] = 8'hEF; mem[32'h0001AC] = 8'h01;
        do_op("R10", 3'd0, 24'h808000, 16'h0000, 16'h0000, 8'h00,
              24'h0001EF, 24'h808002, 24'h0001AB, 4, 2, 1);
    endtask

    task automatic t_reserved;
        for (int c = 5; c < 8; c++) begin
            @(negedge clk);
            log_n = 0; done_cnt = 0;
            start = 1; mode = 3'(c); pc_in = 24'h808000;
            @(negedge clk);
            start = 0;
            repeat (10) @(negedge clk);
            chk("R10", "reserved mode requests", 32'(log_n), 32'd0);
            chk("R10", "reserved mode done", 32'(done_cnt), 32'd0);
        end
    endtask

    task automatic t_mid_reset;
        mem.delete();
        @(negedge clk);
        start = 1; mode = 3'd3; pc_in = 24'h808000; d_reg = 16'h1010;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        rst = 1;
        @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        chk("R1", "idle after reset", 32'(mem_req), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_abs_ind();
        t_abs_x_ind();
        t_abs_x_wrap();
        t_dp_ind();
        t_dp_wrap();
        t_dp_long();
        t_pc_rel();
        t_busy_start();
        t_reserved();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule